// File: doc/BRIEF.md
# Dual-Bank Flash Fetch Arbiter

This block sits between the core's read port and two independent 16-bit flash arrays. The low bank holds 64 kB from 0x0008_0000 and the high bank holds 32 kB from 0x0009_0000. The block decodes each core address to a bank and a halfword index. It drives the array read ports and shapes the returned halfwords into byte, halfword or word results. It also tells the core when the result is ready.

The erase and program engines are outside this block. Each engine reports only a busy flag for its bank. A read aimed at a busy bank is held off until that flag drops, while reads to the other bank go through as usual. Each array has two read ports. When the core clock is divided, the array can serve two halfwords in one core cycle, so both ports are used together. At full speed (divider code zero) only one access fits per core cycle, so a word read is split over two cycles and the first halfword is kept in a register.

The core raises `req_i` and keeps address, size and mode steady until it sees `ready_o` in the same cycle. `ready_o`, `err_o` and `rdata_o` are combinational from the request and the block's own phase register.

Top module: `flash_fetch_arb`

## Requirements
- R1: Addresses 0x0008_0000–0x0008_FFFF select the low bank with halfword index addr[15:1]. Addresses 0x0009_0000–0x0009_7FFF select the high bank with halfword index addr[14:1].
- R2: Access size `size_i` is coded 0 = byte, 1 = halfword, 2 or 3 = word. When `div_code_i` is nonzero, a word read to an idle bank completes in the request cycle. The result is {halfword at index 2k+1, halfword at index 2k}, where k is addr[..:2], so addr[1:0] are ignored.
- R3: When `div_code_i` is zero, a word read takes two cycles. `ready_o` is low in the first cycle and high in the second, and the data is the same as in R2.
- R4: A halfword read completes in one cycle and returns the addressed halfword zero-extended. addr[0] is ignored.
- R5: A byte read completes in one cycle. It returns bits 7:0 of the halfword when addr[0]=0 and bits 15:8 when addr[0]=1, zero-extended.
- R6: A request outside both bank ranges completes in one cycle with `err_o`=1 and `rdata_o`=0xFFFF_FFFF.
- R7: When `user_mode_i`=1, a request to the top 2 kB of the high bank (0x0009_7800–0x0009_7FFF) completes in one cycle with `err_o`=1 and data 0xFFFF_FFFF, even if that bank is busy. With `user_mode_i`=0, the same region reads normally.
- R8: While the addressed bank's busy input is high, `ready_o` stays low. The access completes once busy falls.
- R9: A busy flag on one bank does not delay reads to the other bank.
- R10: With no request, and out of reset, `ready_o`=0, `err_o`=0 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 3 | Core clock divider code; 0 = full speed |
| req_i | input | 1 | Read request, held until ready |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| user_mode_i | input | 1 | Request comes from unprivileged code |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Access rejected (range or protection) |
| rdata_o | output | 32 | Read result |
| busy_lo_i | input | 1 | Low bank busy with erase or program |
| busy_hi_i | input | 1 | High bank busy with erase or program |
| lo_addr_a_o | output | 15 | Low bank port A halfword index |
| lo_addr_b_o | output | 15 | Low bank port B halfword index |
| lo_rdata_a_i | input | 16 | Low bank port A data |
| lo_rdata_b_i | input | 16 | Low bank port B data |
| hi_addr_a_o | output | 14 | High bank port A halfword index |
| hi_addr_b_o | output | 14 | High bank port B halfword index |
| hi_rdata_a_i | input | 16 | High bank port A data |
| hi_rdata_b_i | input | 16 | High bank port B data |

## Verification
The bench reads at the first and last halfword of each bank and just outside the ranges. A decoder off by one bit would misroute or fail to reject these addresses. Full-speed word reads are checked for the extra wait cycle and for the order of the two halfwords. A design that swapped the stored and live halves, or skipped the wait, would give the wrong data or finish a cycle early. The busy tests hold one bank busy while reading the other, and also raise busy on a protected kernel address. A global stall would show up as a missing ready, and a stall placed ahead of the protection check would delay the error response.

// File: rtl/flash_fetch_pkg.sv
package flash_fetch_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam logic [ADDR_W-1:0] LO_BASE_DEF = 32'h0008_0000;
  localparam logic [ADDR_W-1:0] HI_BASE_DEF = 32'h0009_0000;
  localparam int unsigned LO_BYTES_DEF   = 65536;
  localparam int unsigned HI_BYTES_DEF   = 32768;
  localparam int unsigned KERN_BYTES_DEF = 2048;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2
  } tgt_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/flash_fetch_decode.sv
module flash_fetch_decode
  import flash_fetch_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] LO_BASE = 32'h0008_0000,
  parameter logic [AW-1:0] HI_BASE = 32'h0009_0000,
  parameter int unsigned LO_OW = 16,
  parameter int unsigned HI_OW = 15,
  parameter int unsigned KERN_OW = 11
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             user_mode_i,
  output tgt_e             tgt_o,
  output logic             denied_o,
  output logic [LO_OW-2:0] lo_hidx_o,
  output logic [HI_OW-2:0] hi_hidx_o
);
  logic in_lo, in_hi, in_kern;

  // bases are aligned to bank size, so the tag compare is enough
  assign in_lo   = addr_i[AW-1:LO_OW] == LO_BASE[AW-1:LO_OW];
  assign in_hi   = addr_i[AW-1:HI_OW] == HI_BASE[AW-1:HI_OW];
  assign in_kern = in_hi && (&addr_i[HI_OW-1:KERN_OW]);

  always_comb begin
    if (in_lo)      tgt_o = TGT_LO;
    else if (in_hi) tgt_o = TGT_HI;
    else            tgt_o = TGT_NONE;
  end

  assign denied_o  = user_mode_i && in_kern;
  assign lo_hidx_o = addr_i[LO_OW-1:1];
  assign hi_hidx_o = addr_i[HI_OW-1:1];
endmodule

// File: rtl/flash_fetch_port.sv
module flash_fetch_port #(
  parameter int unsigned IW = 15
) (
  input  logic [IW-1:0] hidx_i,
  input  logic          is_word_i,
  input  logic          phase_i,
  output logic [IW-1:0] addr_a_o,
  output logic [IW-1:0] addr_b_o
);
  // port A: single access, or even/odd half by phase; port B: odd half
  assign addr_a_o = is_word_i ? {hidx_i[IW-1:1], phase_i} : hidx_i;
  assign addr_b_o = {hidx_i[IW-1:1], 1'b1};
endmodule

// File: rtl/flash_fetch_lane.sv
module flash_fetch_lane
  import flash_fetch_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic        byte_sel_i,
  input  logic        full_speed_i,
  input  logic [15:0] hw_a_i,
  input  logic [15:0] hw_b_i,
  input  logic [15:0] hw_held_i,
  output logic [31:0] data_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {24'h0, byte_sel_i ? hw_a_i[15:8] : hw_a_i[7:0]};
      SZ_HALF: data_o = {16'h0, hw_a_i};
      default: data_o = full_speed_i ? {hw_a_i, hw_held_i} : {hw_b_i, hw_a_i};
    endcase
  end
endmodule

// File: rtl/flash_fetch_arb.sv
module flash_fetch_arb
  import flash_fetch_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] LO_BASE = LO_BASE_DEF,
  parameter logic [AW-1:0] HI_BASE = HI_BASE_DEF,
  parameter int unsigned LO_BYTES = LO_BYTES_DEF,
  parameter int unsigned HI_BYTES = HI_BYTES_DEF,
  parameter int unsigned KERN_BYTES = KERN_BYTES_DEF,
  parameter int unsigned DW = 32,
  parameter int unsigned HW = 16,
  parameter int unsigned DIV_W = 3,
  localparam int unsigned LO_OW = $clog2(LO_BYTES),
  localparam int unsigned HI_OW = $clog2(HI_BYTES),
  localparam int unsigned KERN_OW = $clog2(KERN_BYTES),
  localparam int unsigned LO_IW = LO_OW - 1,
  localparam int unsigned HI_IW = HI_OW - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic             user_mode_i,
  output logic             ready_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o,
  input  logic             busy_lo_i,
  input  logic             busy_hi_i,
  output logic [LO_IW-1:0] lo_addr_a_o,
  output logic [LO_IW-1:0] lo_addr_b_o,
  input  logic [HW-1:0]    lo_rdata_a_i,
  input  logic [HW-1:0]    lo_rdata_b_i,
  output logic [HI_IW-1:0] hi_addr_a_o,
  output logic [HI_IW-1:0] hi_addr_b_o,
  input  logic [HW-1:0]    hi_rdata_a_i,
  input  logic [HW-1:0]    hi_rdata_b_i
);
  tgt_e             tgt;
  logic             denied;
  logic [LO_IW-1:0] lo_hidx;
  logic [HI_IW-1:0] hi_hidx;
  logic             is_word, full_speed, bank_busy, go, two_step;
  logic             phase_q, phase_d;
  logic [HW-1:0]    held_q;
  logic [HW-1:0]    sel_a, sel_b;
  logic [DW-1:0]    lane_data;

  flash_fetch_decode #(
    .AW(AW), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE),
    .LO_OW(LO_OW), .HI_OW(HI_OW), .KERN_OW(KERN_OW)
  ) u_dec (
    .addr_i     (addr_i),
    .user_mode_i(user_mode_i),
    .tgt_o      (tgt),
    .denied_o   (denied),
    .lo_hidx_o  (lo_hidx),
    .hi_hidx_o  (hi_hidx)
  );

  assign is_word    = size_i[1];
  assign full_speed = div_code_i == '0;
  assign two_step   = is_word && full_speed;

  flash_fetch_port #(.IW(LO_IW)) u_lo_port (
    .hidx_i   (lo_hidx),
    .is_word_i(is_word),
    .phase_i  (phase_q),
    .addr_a_o (lo_addr_a_o),
    .addr_b_o (lo_addr_b_o)
  );

  flash_fetch_port #(.IW(HI_IW)) u_hi_port (
    .hidx_i   (hi_hidx),
    .is_word_i(is_word),
    .phase_i  (phase_q),
    .addr_a_o (hi_addr_a_o),
    .addr_b_o (hi_addr_b_o)
  );

  assign sel_a = (tgt == TGT_HI) ? hi_rdata_a_i : lo_rdata_a_i;
  assign sel_b = (tgt == TGT_HI) ? hi_rdata_b_i : lo_rdata_b_i;

  // protection and range errors never wait on a busy bank
  assign err_o     = req_i && ((tgt == TGT_NONE) || denied);
  assign bank_busy = ((tgt == TGT_LO) && busy_lo_i) || ((tgt == TGT_HI) && busy_hi_i);
  assign go        = req_i && !err_o && !bank_busy;
  assign ready_o   = err_o || (go && (!two_step || phase_q));

  always_comb begin
    phase_d = phase_q;
    if (!req_i)                          phase_d = 1'b0;
    else if (go && two_step && !phase_q) phase_d = 1'b1;
    else if (ready_o)                    phase_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      held_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (go && two_step && !phase_q) held_q <= sel_a;
    end
  end

  flash_fetch_lane u_lane (
    .size_i      (size_i),
    .byte_sel_i  (addr_i[0]),
    .full_speed_i(full_speed),
    .hw_a_i      (sel_a),
    .hw_b_i      (sel_b),
    .hw_held_i   (held_q),
    .data_o      (lane_data)
  );

  always_comb begin
    if (err_o)        rdata_o = '1;
    else if (ready_o) rdata_o = lane_data;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/flash_fetch_arb_chk.sv
module flash_fetch_arb_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned DIV_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_code_i,
  input logic             req_i,
  input logic [AW-1:0]    addr_i,
  input logic [1:0]       size_i,
  input logic             user_mode_i,
  input logic             ready_o,
  input logic             err_o,
  input logic [DW-1:0]    rdata_o,
  input logic             busy_lo_i,
  input logic             busy_hi_i
);
  logic a_lo, a_hi, a_kern;
  assign a_lo   = addr_i >= 32'h0008_0000 && addr_i <= 32'h0008_FFFF;
  assign a_hi   = addr_i >= 32'h0009_0000 && addr_i <= 32'h0009_7FFF;
  assign a_kern = addr_i >= 32'h0009_7800 && addr_i <= 32'h0009_7FFF;

  p_err_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o && rdata_o == '1);

  p_out_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !a_lo && !a_hi |-> err_o && ready_o);

  p_kernel_deny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && user_mode_i && a_kern |-> err_o && ready_o);

  p_busy_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ((a_lo && busy_lo_i) || (a_hi && busy_hi_i && !(user_mode_i && a_kern)))
      |-> !ready_o);

  p_div_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i[1] && div_code_i != '0 && a_lo && !busy_lo_i |-> ready_o && !err_o);

  p_fast_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i[1] && div_code_i == '0 && ready_o && !err_o
      |-> $past(req_i) && !$past(ready_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ready_o && !err_o && rdata_o == '0);
endmodule

bind flash_fetch_arb flash_fetch_arb_chk #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .div_code_i(div_code_i), .req_i(req_i),
  .addr_i(addr_i), .size_i(size_i), .user_mode_i(user_mode_i),
  .ready_o(ready_o), .err_o(err_o), .rdata_o(rdata_o),
  .busy_lo_i(busy_lo_i), .busy_hi_i(busy_hi_i)
);

// File: tb/tb_flash_fetch_arb.sv
module tb_flash_fetch_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  div_code_i = 3'd0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = 2'd0;
  logic        user_mode_i = 1'b0;
  logic        ready_o, err_o;
  logic [31:0] rdata_o;
  logic        busy_lo_i = 1'b0, busy_hi_i = 1'b0;
  logic [14:0] lo_addr_a_o, lo_addr_b_o;
  logic [13:0] hi_addr_a_o, hi_addr_b_o;
  logic [15:0] lo_rdata_a_i, lo_rdata_b_i, hi_rdata_a_i, hi_rdata_b_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  // array models: content is a fixed function of the halfword index
  assign lo_rdata_a_i = {1'b0, lo_addr_a_o} ^ 16'hA5C3;
  assign lo_rdata_b_i = {1'b0, lo_addr_b_o} ^ 16'hA5C3;
  assign hi_rdata_a_i = {2'b0, hi_addr_a_o} ^ 16'h3C96;
  assign hi_rdata_b_i = {2'b0, hi_addr_b_o} ^ 16'h3C96;

  flash_fetch_arb dut (.*);

  function automatic logic [15:0] hw_at(input logic [31:0] a);
    if (a[31:16] == 16'h0008) return {1'b0, a[15:1]} ^ 16'hA5C3;
    return {2'b0, a[14:1]} ^ 16'h3C96;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    return {hw_at(b + 32'd2), hw_at(b)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // issue one read, count wait cycles, compare waits, data and error
  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input bit usr,
                    input int exp_wait, input logic [31:0] exp_d, input bit exp_e,
                    input string tag);
    int waits = 0;
    @(negedge clk_i);
    addr_i = a; size_i = sz; user_mode_i = usr; req_i = 1'b1;
    #5;
    while (!ready_o && waits < 20) begin
      waits++;
      @(negedge clk_i);
      #5;
    end
    check(waits == exp_wait, {tag, " wait"}, 32'(waits), 32'(exp_wait));
    check(rdata_o == exp_d, {tag, " data"}, rdata_o, exp_d);
    check(err_o == exp_e, {tag, " err"}, 32'(err_o), 32'(exp_e));
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    #5;
    check(!ready_o && !err_o && rdata_o == 0, "R10 reset", {30'b0, ready_o, err_o}, 0);
  endtask

  task automatic t_half;
    div_code_i = 3'd2;
    rd(32'h0008_0000, 2'd1, 0, 0, {16'h0, hw_at(32'h0008_0000)}, 0, "R1 R4 lo first");
    rd(32'h0008_FFFE, 2'd1, 0, 0, {16'h0, hw_at(32'h0008_FFFE)}, 0, "R1 R4 lo last");
    rd(32'h0008_0123, 2'd1, 0, 0, {16'h0, hw_at(32'h0008_0122)}, 0, "R4 odd addr");
    rd(32'h0009_0000, 2'd1, 0, 0, {16'h0, hw_at(32'h0009_0000)}, 0, "R1 hi first");
    rd(32'h0009_77FE, 2'd1, 1, 0, {16'h0, hw_at(32'h0009_77FE)}, 0, "R1 R7 below kernel");
  endtask

  task automatic t_byte;
    div_code_i = 3'd0;
    rd(32'h0008_0004, 2'd0, 0, 0, {24'h0, hw_at(32'h0008_0004)[7:0]}, 0, "R5 low lane");
    rd(32'h0008_0005, 2'd0, 0, 0, {24'h0, hw_at(32'h0008_0004)[15:8]}, 0, "R5 high lane");
    rd(32'h0009_0011, 2'd0, 0, 0, {24'h0, hw_at(32'h0009_0010)[15:8]}, 0, "R5 hi bank");
  endtask

  task automatic t_word_div;
    div_code_i = 3'd3;
    rd(32'h0008_0008, 2'd2, 0, 0, word_at(32'h0008_0008), 0, "R2 lo");
    rd(32'h0009_000E, 2'd3, 0, 0, word_at(32'h0009_000C), 0, "R2 unaligned hi");
    rd(32'h0008_FFFC, 2'd2, 0, 0, word_at(32'h0008_FFFC), 0, "R2 lo top");
  endtask

  task automatic t_word_fast;
    div_code_i = 3'd0;
    rd(32'h0008_0010, 2'd2, 0, 1, word_at(32'h0008_0010), 0, "R3 lo");
    rd(32'h0009_7002, 2'd2, 0, 1, word_at(32'h0009_7000), 0, "R3 hi");
    rd(32'h0009_7FFC, 2'd2, 0, 1, word_at(32'h0009_7FFC), 0, "R3 R7 priv kernel");
  endtask

  task automatic t_range;
    rd(32'h0007_FFFE, 2'd1, 0, 0, 32'hFFFF_FFFF, 1, "R6 below");
    rd(32'h0009_8000, 2'd2, 0, 0, 32'hFFFF_FFFF, 1, "R6 above");
    rd(32'h0000_0000, 2'd0, 0, 0, 32'hFFFF_FFFF, 1, "R6 zero");
  endtask

  task automatic t_kernel;
    div_code_i = 3'd1;
    rd(32'h0009_7800, 2'd1, 1, 0, 32'hFFFF_FFFF, 1, "R7 user start");
    rd(32'h0009_7FFC, 2'd2, 1, 0, 32'hFFFF_FFFF, 1, "R7 user end");
    rd(32'h0009_7800, 2'd1, 0, 0, {16'h0, hw_at(32'h0009_7800)}, 0, "R7 priv");
    busy_hi_i = 1'b1;
    rd(32'h0009_7A00, 2'd0, 1, 0, 32'hFFFF_FFFF, 1, "R7 user busy");
    busy_hi_i = 1'b0;
  endtask

  task automatic t_busy;
    div_code_i = 3'd2;
    busy_hi_i = 1'b1;
    rd(32'h0008_0040, 2'd2, 0, 0, word_at(32'h0008_0040), 0, "R9 lo while hi busy");
    @(negedge clk_i);
    addr_i = 32'h0009_0100; size_i = 2'd1; user_mode_i = 0; req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #5;
      check(!ready_o, "R8 hi stalled", 32'(ready_o), 0);
      @(negedge clk_i);
    end
    busy_hi_i = 1'b0;
    #5;
    check(ready_o && rdata_o == {16'h0, hw_at(32'h0009_0100)}, "R8 hi released",
          rdata_o, {16'h0, hw_at(32'h0009_0100)});
    @(posedge clk_i); #1;
    req_i = 1'b0;
    // full-speed word with busy rising between halves
    div_code_i = 3'd0;
    @(negedge clk_i);
    addr_i = 32'h0008_0200; size_i = 2'd2; req_i = 1'b1;
    #5;
    check(!ready_o, "R3 first half", 32'(ready_o), 0);
    @(negedge clk_i);
    busy_lo_i = 1'b1;
    #5;
    check(!ready_o, "R8 second half stalled", 32'(ready_o), 0);
    @(negedge clk_i);
    busy_lo_i = 1'b0;
    #5;
    check(ready_o && rdata_o == word_at(32'h0008_0200), "R8 R3 resumed",
          rdata_o, word_at(32'h0008_0200));
    busy_hi_i = 1'b1;
    #1;
    check(ready_o, "R9 lo with hi busy", 32'(ready_o), 1);
    @(posedge clk_i); #1;
    req_i = 1'b0; busy_hi_i = 1'b0;
    #2;
    check(!ready_o && !err_o && rdata_o == 0, "R10 idle", rdata_o, 0);
  endtask

  initial begin
    #1;
    t_reset;
    #40 rst_ni = 1'b1;
    t_half;
    t_byte;
    t_word_div;
    t_word_fast;
    t_range;
    t_kernel;
    t_busy;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule